// File: doc/BRIEF.md
# Serial Character Transmitter with Line Flow Control

This block takes bytes from a processor-side write stream, queues them in a small transmit FIFO and shifts each one out on a single serial line as an asynchronous character. The frame shape is chosen by plain configuration inputs: 5 to 8 data bits, parity that can be turned off or set to even or odd, and one or two stop bits. Bit timing comes from an external baud divider as a one-cycle `bit_tick` strobe. The shifter captures the frame shape when a character starts, so changing the configuration while characters are queued affects only characters that start after the change.

One-cycle command pulses enable, disable or reset the transmitter and start or stop a break. A clear-to-send input can hold characters back. It is checked only when a new character is about to start. A driver-enable output can steer an RS-485 transceiver: it stays high until every queued byte, including its last stop bit, has left the line.

The write port uses valid/ready. A byte moves when `wr_valid` and `wr_ready` are both high at a rising clock edge. `wr_ready` drops when the transmitter is disabled or the FIFO is full. A byte offered while the transmitter is disabled is discarded. A byte offered while the transmitter is enabled and the FIFO is full is also discarded, and the overflow flag is set. Commands sent in the same cycle take effect in this priority order: reset, then disable, then enable.

Top module: `txl_top`

## Requirements
- R1: `wr_ready` is high exactly when the transmitter is enabled and the FIFO is not full. It is low in the cycle after a disable or reset command.
- R2: A byte offered while the transmitter is disabled is neither stored nor sent, and it does not set the overflow flag.
- R3: A byte offered while the transmitter is enabled and the FIFO is full is dropped, and `ovf_flag` rises. The flag stays high until a reset command.
- R4: Each frame has the following parts, in order:
  - a low start bit;
  - 5 + `cfg_dbits` data bits, least significant bit first (`cfg_dbits` 0 gives 5 bits, 3 gives 8);
  - when `cfg_par_en` is high, a parity bit that makes the count of ones over the data and parity bits even (`cfg_par_odd` = 0) or odd (`cfg_par_odd` = 1);
  - one high stop bit, or two when `cfg_two_stop` is high.

  The line changes at the clock edge where `bit_tick` is high, and each bit lasts one tick interval.
- R5: Queued characters go out back to back. When the last stop bit ends and the FIFO is empty, `txd` stays high and `tx_idle` is 1. `tx_idle` falls in the cycle after a byte is accepted.
- R6: After a disable command, the character on the line finishes. Queued bytes stay in the FIFO and start only after an enable command.
- R7: Break-on drives `txd` low from the next cycle until break-off, and no character starts during a break.
- R8: A reset command does all of the following in the next cycle:
  - drives `txd` high, stopping the character in progress;
  - empties the FIFO;
  - clears the overflow flag and any break;
  - leaves the transmitter disabled.
- R9: With `cfg_cts_gate` high, a character starts only if `cts` is low at the tick where it would start. While `cts` is high, that character and all later ones wait.
- R10: A rise of `cts` while a character is being shifted out does not change that character.
- R11: With `cfg_rts_auto` high, `drv_en` is high while any byte is queued or on the line. It goes low when the FIFO is empty and the last stop bit has ended. With `cfg_rts_auto` low, `drv_en` is always low.
- R12: After `rst_n`, the transmitter is disabled, `txd` is high, `tx_idle` is 1, and `ovf_flag` and `drv_en` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_tick | input | 1 | One-cycle bit-time strobe from the baud divider |
| cmd_enable | input | 1 | Enable command pulse |
| cmd_disable | input | 1 | Disable command pulse |
| cmd_reset | input | 1 | Transmitter reset command pulse |
| cmd_break_on | input | 1 | Start-break command pulse |
| cmd_break_off | input | 1 | Stop-break command pulse |
| cfg_dbits | input | 2 | Data bits minus 5 |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1 selects odd parity, 0 selects even |
| cfg_two_stop | input | 1 | 1 selects two stop bits |
| cfg_cts_gate | input | 1 | Gate each character start on `cts` |
| cfg_rts_auto | input | 1 | Drive `drv_en` for RS-485 direction control |
| cts | input | 1 | Clear to send; high holds characters |
| wr_valid | input | 1 | Write stream valid |
| wr_data | input | 8 | Write stream byte |
| wr_ready | output | 1 | Write stream ready; also the transmit-ready status |
| txd | output | 1 | Serial line, idles high |
| tx_idle | output | 1 | FIFO empty and no character on the line |
| drv_en | output | 1 | Transceiver driver enable |
| ovf_flag | output | 1 | Sticky FIFO overflow flag |

## Verification
The bench builds the block with a FIFO depth of 4 and a tick every 4 cycles. With a depth of 4, only four accepted bytes fill the FIFO, so the full state, the dropped fifth byte and the sticky flag are easy to reach. With a 4-cycle tick, a 12-bit frame takes under 50 cycles. A frame can therefore be interrupted mid-character by a disable, a reset or a `cts` change at a chosen bit. The bench also covers the four data widths with each parity and stop-bit choice.

// File: rtl/txl_pkg.sv
package txl_pkg;

  localparam int FRAME_W = 12;

  typedef struct packed {
    logic [1:0] dbits;
    logic       par_en;
    logic       par_odd;
    logic       two_stop;
  } txl_fmt_t;

  // Serial image of one character, bit 0 goes out first; unused tail is idle level.
  function automatic logic [FRAME_W-1:0] mk_frame(input logic [7:0] d, input txl_fmt_t f);
    logic [FRAME_W-1:0] v;
    logic par;
    int nd;
    nd  = 5 + int'(f.dbits);
    v   = '1;
    v[0] = 1'b0;
    par = f.par_odd;
    for (int i = 0; i < 8; i++) begin
      if (i < nd) begin
        v[i+1] = d[i];
        par    = par ^ d[i];
      end
    end
    if (f.par_en) v[nd+1] = par;
    return v;
  endfunction

  function automatic logic [3:0] frame_len(input txl_fmt_t f);
    return 4'd7 + {2'b00, f.dbits} + {3'b000, f.par_en} + {3'b000, f.two_stop};
  endfunction

endpackage

// File: rtl/txl_fifo.sv
module txl_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [DW-1:0] din,
  input  logic          pop,
  output logic [DW-1:0] dout,
  output logic          empty,
  output logic          full
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else if (flush) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= wp + 1'b1;
      if (pop)  rp <= rp + 1'b1;
      case ({push, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  assign dout  = mem[rp];
  assign empty = (cnt == '0);
  assign full  = (cnt == CW'(DEPTH));

endmodule

// File: rtl/txl_shifter.sv
module txl_shifter
  import txl_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           abort,
  input  logic           tick,
  input  logic           allow,
  input  logic           avail,
  input  logic           cts_gate,
  input  logic           cts,
  input  txl_fmt_t       fmt,
  input  logic [7:0]     data,
  output logic           pop,
  output logic           busy,
  output logic           line
);
  logic [FRAME_W-1:0] sh;
  logic [3:0]         rem;
  logic               last, go;

  assign last = busy && (rem == 4'd0);
  // clear-to-send is looked at only when a new character would begin
  assign go   = tick && (!busy || last) && allow && avail && !(cts_gate && cts);
  assign pop  = go;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh   <= '1;
      rem  <= '0;
      busy <= 1'b0;
    end else if (abort) begin
      sh   <= '1;
      rem  <= '0;
      busy <= 1'b0;
    end else if (tick) begin
      if (busy && !last) begin
        sh  <= {1'b1, sh[FRAME_W-1:1]};
        rem <= rem - 1'b1;
      end else if (go) begin
        sh   <= mk_frame(data, fmt);
        rem  <= frame_len(fmt) - 4'd1;
        busy <= 1'b1;
      end else begin
        sh   <= '1;
        busy <= 1'b0;
      end
    end
  end

  assign line = sh[0];

endmodule

// File: rtl/txl_top.sv
module txl_top
  import txl_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_tick,
  input  logic       cmd_enable,
  input  logic       cmd_disable,
  input  logic       cmd_reset,
  input  logic       cmd_break_on,
  input  logic       cmd_break_off,
  input  logic [1:0] cfg_dbits,
  input  logic       cfg_par_en,
  input  logic       cfg_par_odd,
  input  logic       cfg_two_stop,
  input  logic       cfg_cts_gate,
  input  logic       cfg_rts_auto,
  input  logic       cts,
  input  logic       wr_valid,
  input  logic [7:0] wr_data,
  output logic       wr_ready,
  output logic       txd,
  output logic       tx_idle,
  output logic       drv_en,
  output logic       ovf_flag
);
  logic en_q, brk_q, ovf_q;
  logic f_empty, f_full, f_pop, push;
  logic [7:0] f_dout;
  logic busy, line;
  txl_fmt_t fmt;

  assign fmt      = '{dbits: cfg_dbits, par_en: cfg_par_en, par_odd: cfg_par_odd,
                      two_stop: cfg_two_stop};
  assign wr_ready = en_q && !f_full;
  assign push     = wr_valid && wr_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      brk_q <= 1'b0;
      ovf_q <= 1'b0;
    end else if (cmd_reset) begin
      en_q  <= 1'b0;
      brk_q <= 1'b0;
      ovf_q <= 1'b0;
    end else begin
      if (cmd_disable)     en_q <= 1'b0;
      else if (cmd_enable) en_q <= 1'b1;
      if (cmd_break_on)       brk_q <= 1'b1;
      else if (cmd_break_off) brk_q <= 1'b0;
      if (wr_valid && en_q && f_full) ovf_q <= 1'b1;
    end
  end

  txl_fifo #(.DW(8), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .flush(cmd_reset),
    .push(push), .din(wr_data), .pop(f_pop), .dout(f_dout),
    .empty(f_empty), .full(f_full)
  );

  txl_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .abort(cmd_reset), .tick(bit_tick),
    .allow(en_q && !brk_q), .avail(!f_empty),
    .cts_gate(cfg_cts_gate), .cts(cts), .fmt(fmt), .data(f_dout),
    .pop(f_pop), .busy(busy), .line(line)
  );

  assign txd      = brk_q ? 1'b0 : line;
  assign tx_idle  = !busy && f_empty;
  assign drv_en   = cfg_rts_auto && !tx_idle;
  assign ovf_flag = ovf_q;

endmodule

// File: rtl/txl_chk.sv
module txl_chk (
  input logic clk,
  input logic rst_n,
  input logic cmd_reset,
  input logic cmd_disable,
  input logic cmd_break_on,
  input logic wr_valid,
  input logic wr_ready,
  input logic txd,
  input logic tx_idle,
  input logic drv_en,
  input logic ovf_flag,
  input logic brk_q
);
  p_disable_ready_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_disable |=> !wr_ready);

  p_idle_keeps_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_idle && !wr_ready) |=> tx_idle);

  p_ovf_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_flag) |-> $past(wr_valid && !wr_ready));

  p_ovf_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !cmd_reset) |=> ovf_flag);

  p_idle_line_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_idle && !brk_q) |-> txd);

  p_break_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_break_on && !cmd_reset) |=> !txd);

  p_reset_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_reset |=> (txd && tx_idle && !wr_ready && !ovf_flag));

  p_drv_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    tx_idle |-> !drv_en);

endmodule

bind txl_top txl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_reset(cmd_reset), .cmd_disable(cmd_disable),
  .cmd_break_on(cmd_break_on), .wr_valid(wr_valid), .wr_ready(wr_ready),
  .txd(txd), .tx_idle(tx_idle), .drv_en(drv_en), .ovf_flag(ovf_flag),
  .brk_q(brk_q)
);

// File: tb/txl_top_tb_top.sv
module txl_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int TICKDIV    = 4;
  localparam int DEPTH      = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_tick = 1'b0;
  logic cmd_enable = 0, cmd_disable = 0, cmd_reset = 0, cmd_break_on = 0, cmd_break_off = 0;
  logic [1:0] cfg_dbits = 2'd3;
  logic cfg_par_en = 0, cfg_par_odd = 0, cfg_two_stop = 0, cfg_cts_gate = 0, cfg_rts_auto = 0;
  logic cts = 0;
  logic wr_valid = 0;
  logic [7:0] wr_data = '0;
  logic wr_ready, txd, tx_idle, drv_en, ovf_flag;

  int n_chk = 0, n_bad = 0;
  bit mon_on = 1'b1;

  typedef struct {
    logic [7:0] d;
    logic [1:0] db;
    logic pe, po, ts;
  } exp_t;
  exp_t q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  int tcnt = 0;
  always @(posedge clk) begin
    tcnt     <= (tcnt == TICKDIV-1) ? 0 : tcnt + 1;
    bit_tick <= (tcnt == TICKDIV-1);
  end

  txl_top #(.DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick),
    .cmd_enable(cmd_enable), .cmd_disable(cmd_disable), .cmd_reset(cmd_reset),
    .cmd_break_on(cmd_break_on), .cmd_break_off(cmd_break_off),
    .cfg_dbits(cfg_dbits), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
    .cfg_two_stop(cfg_two_stop), .cfg_cts_gate(cfg_cts_gate), .cfg_rts_auto(cfg_rts_auto),
    .cts(cts), .wr_valid(wr_valid), .wr_data(wr_data), .wr_ready(wr_ready),
    .txd(txd), .tx_idle(tx_idle), .drv_en(drv_en), .ovf_flag(ovf_flag)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // monitor: decodes frames on txd and compares with the scoreboard queue
  int mstate = 0, mcnt = 0, bidx = 0, nbits = 0;
  logic prev = 1'b1;
  logic ebits [12];
  always @(negedge clk) begin
    if (!mon_on || !rst_n) begin
      mstate = 0;
      prev   = txd;
    end else if (mstate == 0) begin
      if (prev && !txd) begin
        if (q.size() == 0) begin
          check("R4 unexpected frame start", 1, 0);
        end else begin
          exp_t e;
          logic par;
          int nd;
          e  = q.pop_front();
          nd = 5 + int'(e.db);
          par = e.po;
          ebits[0] = 1'b0;
          for (int i = 0; i < nd; i++) begin
            ebits[i+1] = e.d[i];
            par = par ^ e.d[i];
          end
          nbits = nd + 1;
          if (e.pe) begin ebits[nbits] = par; nbits++; end
          ebits[nbits] = 1'b1; nbits++;
          if (e.ts) begin ebits[nbits] = 1'b1; nbits++; end
          mcnt = TICKDIV/2; bidx = 0; mstate = 1;
        end
      end
      prev = txd;
    end else begin
      mcnt--;
      if (mcnt == 0) begin
        check($sformatf("R4 frame bit %0d", bidx), {31'b0, txd}, {31'b0, ebits[bidx]});
        bidx++;
        if (bidx == nbits) begin mstate = 0; prev = txd; end
        else mcnt = TICKDIV;
      end
    end
  end

  task automatic wr(input logic [7:0] d, output logic acc);
    exp_t e;
    @(negedge clk);
    wr_valid = 1'b1; wr_data = d;
    acc = wr_ready;
    if (acc) begin
      e.d = d; e.db = cfg_dbits; e.pe = cfg_par_en; e.po = cfg_par_odd; e.ts = cfg_two_stop;
      q.push_back(e);
    end
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    case (which)
      0: cmd_enable = 1; 1: cmd_disable = 1; 2: cmd_reset = 1;
      3: cmd_break_on = 1; default: cmd_break_off = 1;
    endcase
    @(negedge clk);
    cmd_enable = 0; cmd_disable = 0; cmd_reset = 0; cmd_break_on = 0; cmd_break_off = 0;
  endtask

  task automatic idle_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_start();
    for (int i = 0; i < 500; i++) begin
      @(negedge clk);
      if (!txd) return;
    end
    check("R4 frame never started", 0, 1);
  endtask

  task automatic drain(input string tag);
    int k = 0;
    while (!tx_idle && k < 3000) begin @(negedge clk); k++; end
    idle_cycles(4);
    check({tag, " queue drained"}, q.size(), 0);
    check({tag, " idle after drain"}, {31'b0, tx_idle}, 1);
    check({tag, " line high after drain"}, {31'b0, txd}, 1);
  endtask

  bit done = 1'b0;
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic acc;
    idle_cycles(5);
    rst_n = 1'b1;
    idle_cycles(1);
    // R12 reset state
    check("R12 txd", {31'b0, txd}, 1);
    check("R12 ready", {31'b0, wr_ready}, 0);
    check("R12 idle", {31'b0, tx_idle}, 1);
    check("R12 ovf", {31'b0, ovf_flag}, 0);
    check("R12 drv_en", {31'b0, drv_en}, 0);

    // R2 write while disabled is ignored
    wr(8'h55, acc);
    check("R2 not accepted", {31'b0, acc}, 0);
    check("R2 no overflow", {31'b0, ovf_flag}, 0);
    pulse(0);
    check("R1 ready after enable", {31'b0, wr_ready}, 1);
    idle_cycles(60);
    check("R2 nothing sent", {31'b0, tx_idle}, 1);

    // R4/R5 frames in several shapes
    wr(8'hA5, acc); wr(8'h3C, acc);
    check("R5 idle clears after write", {31'b0, tx_idle}, 0);
    check("R11 drv_en off when mode off", {31'b0, drv_en}, 0);
    drain("R5 8N1");
    cfg_dbits = 2'd0; cfg_par_en = 1; cfg_par_odd = 0; cfg_two_stop = 1;
    wr(8'h13, acc); wr(8'h1F, acc);
    drain("R4 5E2");
    cfg_dbits = 2'd2; cfg_par_odd = 1; cfg_two_stop = 0;
    wr(8'h7F, acc); wr(8'h00, acc);
    drain("R4 7O1");
    cfg_dbits = 2'd1; cfg_par_en = 0; cfg_two_stop = 1;
    wr(8'h2A, acc);
    drain("R4 6N2");
    cfg_dbits = 2'd3; cfg_two_stop = 0;

    // R3 overflow and R9 hold while cts high
    cfg_cts_gate = 1; cts = 1;
    for (int i = 0; i < DEPTH; i++) wr(8'h10 + 8'(i), acc);
    check("R1 ready low when full", {31'b0, wr_ready}, 0);
    wr(8'hEE, acc);
    check("R3 full write dropped", {31'b0, acc}, 0);
    idle_cycles(1);
    check("R3 overflow set", {31'b0, ovf_flag}, 1);
    idle_cycles(60);
    check("R9 held: line high", {31'b0, txd}, 1);
    check("R9 held: not idle", {31'b0, tx_idle}, 0);
    check("R9 held: nothing sent", q.size(), DEPTH);
    cts = 0;
    drain("R9 release");
    check("R3 overflow sticky", {31'b0, ovf_flag}, 1);

    // R10 cts rise mid-character
    wr(8'h81, acc); wr(8'h42, acc);
    wait_start();
    idle_cycles(8);
    cts = 1;
    idle_cycles(60);
    check("R10 first char complete", q.size(), 1);
    check("R9 second held", {31'b0, tx_idle}, 0);
    check("R9 line high while held", {31'b0, txd}, 1);
    cts = 0;
    drain("R10");
    cfg_cts_gate = 0;

    // R6 disable mid-character
    wr(8'h11, acc); wr(8'h22, acc);
    wait_start();
    idle_cycles(6);
    pulse(1);
    check("R1 ready low after disable", {31'b0, wr_ready}, 0);
    idle_cycles(60);
    check("R6 current char finished", q.size(), 1);
    check("R6 queued byte kept", {31'b0, tx_idle}, 0);
    check("R6 line high", {31'b0, txd}, 1);
    wr(8'h33, acc);
    check("R2 write ignored while disabled", {31'b0, acc}, 0);
    pulse(0);
    drain("R6 resume");

    // R7 break
    mon_on = 0;
    pulse(3);
    check("R7 break low", {31'b0, txd}, 0);
    idle_cycles(30);
    check("R7 break held", {31'b0, txd}, 0);
    mon_on = 1;
    wr(8'h44, acc);
    idle_cycles(30);
    check("R7 no start during break", {31'b0, txd}, 0);
    check("R7 byte waits", q.size(), 1);
    pulse(4);
    drain("R7 after break");

    // R11 driver enable
    cfg_rts_auto = 1;
    wr(8'h99, acc);
    check("R11 drv_en on when queued", {31'b0, drv_en}, 1);
    wait_start();
    idle_cycles(30);
    check("R11 drv_en on during frame", {31'b0, drv_en}, 1);
    drain("R11");
    check("R11 drv_en off after last stop", {31'b0, drv_en}, 0);
    cfg_rts_auto = 0;

    // R8 reset mid-character
    mon_on = 0;
    wr(8'h5A, acc); wr(8'h5B, acc);
    wait_start();
    idle_cycles(6);
    pulse(2);
    check("R8 line high", {31'b0, txd}, 1);
    check("R8 fifo emptied", {31'b0, tx_idle}, 1);
    check("R8 disabled", {31'b0, wr_ready}, 0);
    check("R8 overflow cleared", {31'b0, ovf_flag}, 0);
    q.delete();
    idle_cycles(60);
    check("R8 stays stopped", {31'b0, txd}, 1);
    mon_on = 1;
    pulse(0);
    wr(8'hC3, acc);
    drain("R8 after re-enable");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule